// File: doc/BRIEF.md
# Two-Wire Register Slave with Auto-Incrementing Pointer

This block lets a host on a two-wire serial bus read and write a small file of byte-wide registers. It runs on a fast system clock and samples SCL and SDA through two-flop synchronizers. It finds START, repeated START and STOP from the sampled lines. It pulls SDA low through an open-drain enable (`sdaOe` high means the pad drives low). Clock stretching is not used.

The 7-bit device address is `01010` followed by two bits chosen by a 2-bit strap input. A host first sends the address with the write bit and then a register number, which loads an internal pointer. The host may then send data bytes, each stored at the pointer. It may instead issue a repeated START and the address with the read bit, and then collect bytes from the pointer. The pointer steps by one after every data byte in either direction. It wraps from the last register to the first. User logic has its own read/write port on the same register file.

Top module: `twi_reg_slave`

## Requirements
- R1: After reset `sdaOe` is 0 and all 32 registers read 0x00 on the user port.
- R2: The device answers to 7-bit address {01010, s1, s0}. Strap code 2'b00 selects s1s0=00 (address byte 0x50/0x51). Code 2'b01 selects 01 (0x52/0x53). Code 2'b10 selects 10 (0x54/0x55). Code 2'b11 is treated like 2'b00.
- R3: On a matching address byte the slave holds SDA low for the whole ninth (acknowledge) clock. It also acknowledges every register-number byte and every written data byte.
- R4: On a non-matching address byte the slave gives no acknowledge and keeps SDA released. It ignores all further bytes, so no register changes, until the next START.
- R5: The byte after an address with the write bit (bit 0 = 0) loads the pointer from its low 5 bits. Bits 7..5 are ignored.
- R6: Each further written data byte is stored at the pointer. A STOP ends the write.
- R7: The pointer steps by one after each written byte and wraps from 0x1F to 0x00.
- R8: After a repeated START and an address with the read bit (bit 0 = 1), the slave sends the register at the pointer, MSB first.
- R9: A master acknowledge (SDA low on the ninth clock) after a read byte steps the pointer, with wrap from 0x1F to 0x00, and the next register is sent. A master no-acknowledge makes the slave release SDA and stay silent until the next START.
- R10: The slave changes `sdaOe` only while SCL is low.
- R11: A START or STOP in the middle of a byte abandons that byte. A partly received data byte is never written, and the slave then works normally.
- R12: A user write with `usrWe` high stores `usrWdata` at `usrAddr`. `usrRdata` always shows the register at `usrAddr`, and bus reads return user-written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad |
| sdaOe | output | 1 | Open-drain enable, 1 pulls SDA low |
| strap | input | 2 | Encoded address strap (00 ground, 01 supply, 10 open) |
| usrAddr | input | 5 | User port register index |
| usrWe | input | 1 | User port write strobe |
| usrWdata | input | 8 | User port write data |
| usrRdata | output | 8 | User port read data at `usrAddr` |

## Verification
The assertions take a well-behaved master for granted. The master moves SDA only while SCL is low, except for START and STOP. It never issues START or STOP while the slave is pulling SDA low. It holds each SCL phase for many system clocks, so the two-stage synchronizer never sees a change on both lines at once. The bench's bit-banged master holds each quarter of an SCL period for ten system clocks. It changes SDA a full quarter after SCL falls and samples a quarter after SCL rises. It releases SDA on every acknowledge and read bit, so the wired-AND line stays legal through sweeps over every strap code, every candidate address, and bursts that wrap the pointer.

// File: rtl/twi_reg_pkg.sv
package twi_reg_pkg;

  // Fixed upper part of the 7-bit device address; the strap fills the low two bits.
  localparam logic [4:0] ADDR_FIXED = 5'b01010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RXADDR,
    ST_RXREG,
    ST_RXDATA,
    ST_ACKAW,
    ST_ACKAR,
    ST_ACKREG,
    ST_ACKDATA,
    ST_TX,
    ST_MACK,
    ST_IGNORE
  } state_e;

  // Strobes from control to datapath, at most a few active per cycle.
  typedef struct packed {
    logic shiftIn;   // shift synchronized SDA into the receive byte
    logic ptrLoad;   // load pointer from received register number
    logic ptrInc;    // step pointer with wrap
    logic wrEn;      // store received byte at pointer
    logic txLoad;    // load transmit byte from register at next pointer
    logic txShift;   // present next transmit bit
    logic ackOn;     // pull SDA low for acknowledge
    logic sdaRel;    // release SDA
  } dpCtl_t;

endpackage

// File: rtl/twi_reg_datapath.sv
module twi_reg_datapath
  import twi_reg_pkg::*;
#(
  parameter int REG_COUNT = 32,
  parameter int DATA_W    = 8,
  localparam int PTR_W    = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              sdaBit,
  output logic [DATA_W-1:0] rxByte,
  output logic [PTR_W-1:0]  ptr,
  output logic              sdaOe,
  input  logic [PTR_W-1:0]  usrAddr,
  input  logic              usrWe,
  input  logic [DATA_W-1:0] usrWdata,
  output logic [DATA_W-1:0] usrRdata
);

  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(REG_COUNT - 1);

  logic [DATA_W-1:0] regs [REG_COUNT];
  logic [DATA_W-1:0] txReg;
  logic [PTR_W-1:0]  ptrNext;

  always_comb begin
    ptrNext = ptr;
    if (ctl.ptrLoad)      ptrNext = rxByte[PTR_W-1:0];
    else if (ctl.ptrInc)  ptrNext = (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      ptr    <= '0;
      txReg  <= '0;
      sdaOe  <= 1'b0;
    end else begin
      ptr <= ptrNext;
      if (ctl.shiftIn) rxByte <= {rxByte[DATA_W-2:0], sdaBit};
      if (ctl.txLoad)       txReg <= regs[ptrNext];
      else if (ctl.txShift) txReg <= txReg << 1;
      if (ctl.sdaRel)       sdaOe <= 1'b0;
      else if (ctl.txLoad)  sdaOe <= ~regs[ptrNext][DATA_W-1];
      else if (ctl.txShift) sdaOe <= ~txReg[DATA_W-2];
      else if (ctl.ackOn)   sdaOe <= 1'b1;
    end
  end

  // Register file: bus write takes priority over a same-cycle user write.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
    end else if (ctl.wrEn) begin
      regs[ptr] <= rxByte;
    end else if (usrWe) begin
      regs[usrAddr] <= usrWdata;
    end
  end

  assign usrRdata = regs[usrAddr];

endmodule

// File: rtl/twi_reg_ctrl.sv
module twi_reg_ctrl
  import twi_reg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [1:0]        strap,
  input  logic [DATA_W-1:0] rxByte,
  output logic              sclS,
  output logic              sdaS,
  output dpCtl_t            ctl,
  output state_e            st
);

  localparam int            CNT_W    = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

  logic [1:0]       sclSync, sdaSync;
  logic             sclPrev, sdaPrev;
  logic [CNT_W-1:0] bitCnt, cntN;
  logic             mAck, mAckN;
  state_e           stN;
  logic [1:0]       strapBits;
  logic [6:0]       devAddr;
  logic             sclRise, sclFall, startDet, stopDet, addrHit;

  assign sclS = sclSync[1];
  assign sdaS = sdaSync[1];

  always_comb begin
    case (strap)
      2'b01:   strapBits = 2'b01;
      2'b10:   strapBits = 2'b10;
      default: strapBits = 2'b00;
    endcase
  end

  assign devAddr  = {ADDR_FIXED, strapBits};
  assign addrHit  = (rxByte[DATA_W-1 -: 7] == devAddr);
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
      bitCnt  <= '0;
      mAck    <= 1'b0;
      st      <= ST_IDLE;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
      bitCnt  <= cntN;
      mAck    <= mAckN;
      st      <= stN;
    end
  end

  always_comb begin
    ctl   = '0;
    stN   = st;
    cntN  = bitCnt;
    mAckN = mAck;
    if (startDet) begin
      ctl.sdaRel = 1'b1;
      stN  = ST_RXADDR;
      cntN = '0;
    end else if (stopDet) begin
      ctl.sdaRel = 1'b1;
      stN  = ST_IDLE;
    end else begin
      case (st)
        ST_RXADDR, ST_RXREG, ST_RXDATA: begin
          if (sclRise && bitCnt != CNT_FULL) begin
            ctl.shiftIn = 1'b1;
            cntN = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == CNT_FULL) begin
            if (st == ST_RXADDR) begin
              if (addrHit) begin
                ctl.ackOn = 1'b1;
                stN = rxByte[0] ? ST_ACKAR : ST_ACKAW;
              end else begin
                stN = ST_IGNORE;
              end
            end else if (st == ST_RXREG) begin
              ctl.ptrLoad = 1'b1;
              ctl.ackOn   = 1'b1;
              stN = ST_ACKREG;
            end else begin
              ctl.wrEn  = 1'b1;
              ctl.ackOn = 1'b1;
              stN = ST_ACKDATA;
            end
          end
        end
        ST_ACKAW, ST_ACKREG, ST_ACKDATA: begin
          if (sclFall) begin
            ctl.sdaRel = 1'b1;
            ctl.ptrInc = (st == ST_ACKDATA);
            cntN = '0;
            stN  = (st == ST_ACKAW) ? ST_RXREG : ST_RXDATA;
          end
        end
        ST_ACKAR: begin
          if (sclFall) begin
            ctl.txLoad = 1'b1;
            cntN = '0;
            stN  = ST_TX;
          end
        end
        ST_TX: begin
          if (sclRise) begin
            cntN = bitCnt + 1'b1;
          end else if (sclFall) begin
            if (bitCnt == CNT_FULL) begin
              ctl.sdaRel = 1'b1;
              stN = ST_MACK;
            end else begin
              ctl.txShift = 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            mAckN = ~sdaS;
          end else if (sclFall) begin
            if (mAck) begin
              ctl.ptrInc = 1'b1;
              ctl.txLoad = 1'b1;
              cntN = '0;
              stN  = ST_TX;
            end else begin
              stN = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave
  import twi_reg_pkg::*;
#(
  parameter int REG_COUNT = 32,
  parameter int DATA_W    = 8,
  localparam int PTR_W    = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic [1:0]        strap,
  input  logic [PTR_W-1:0]  usrAddr,
  input  logic              usrWe,
  input  logic [DATA_W-1:0] usrWdata,
  output logic [DATA_W-1:0] usrRdata
);

  dpCtl_t            ctl;
  state_e            st;
  logic              sclS, sdaS;
  logic [DATA_W-1:0] rxByte;
  logic [PTR_W-1:0]  ptr;

  twi_reg_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strap(strap),
    .rxByte(rxByte), .sclS(sclS), .sdaS(sdaS), .ctl(ctl), .st(st)
  );

  twi_reg_datapath #(.REG_COUNT(REG_COUNT), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdaBit(sdaS), .rxByte(rxByte),
    .ptr(ptr), .sdaOe(sdaOe), .usrAddr(usrAddr), .usrWe(usrWe),
    .usrWdata(usrWdata), .usrRdata(usrRdata)
  );

endmodule

// File: rtl/twi_reg_slave_chk.sv
module twi_reg_slave_chk
  import twi_reg_pkg::*;
#(
  parameter int REG_COUNT = 32,
  localparam int PTR_W    = $clog2(REG_COUNT)
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclS,
  input logic             sdaOe,
  input dpCtl_t           ctl,
  input state_e           st,
  input logic [PTR_W-1:0] ptr
);

  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(REG_COUNT - 1);

  // R10
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclS);

  // R4
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IGNORE) |-> !sdaOe);

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IDLE) |-> !sdaOe);

  // R7
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ptrInc |=> (ptr == (($past(ptr) == PTR_LAST) ? '0 : $past(ptr) + 1'b1)));

  // R6
  write_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrEn |-> (st == ST_RXDATA));

  // R8
  tx_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.txShift |-> (st == ST_TX));

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.shiftIn, ctl.ptrLoad, ctl.wrEn, ctl.txLoad, ctl.txShift}));

endmodule

bind twi_reg_slave twi_reg_slave_chk #(.REG_COUNT(REG_COUNT)) u_chk (
  .clk(clk), .rstN(rstN), .sclS(sclS), .sdaOe(sdaOe),
  .ctl(ctl), .st(st), .ptr(ptr)
);

// File: tb/twi_reg_slave_tb.sv
`timescale 1ns/1ps
module twi_reg_slave_tb;

  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic [1:0] strap = 2'b00;
  logic [4:0] usrAddr = '0;
  logic       usrWe = 1'b0;
  logic [7:0] usrWdata = '0;
  logic       sdaOe;
  logic [7:0] usrRdata;
  wire        sdaLine = sdaM & ~sdaOe;

  int nChecks = 0;
  int nFail = 0;
  int edgeViol = 0;
  logic prevOe = 1'b0;
  logic [7:0] model [32];

  always #4 clk = ~clk;

  twi_reg_slave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .strap(strap), .usrAddr(usrAddr), .usrWe(usrWe), .usrWdata(usrWdata),
    .usrRdata(usrRdata)
  );

  // R10 monitor: enable may only move while the master holds SCL low
  always @(negedge clk) begin
    if (rstN && (sdaOe !== prevOe) && sclM) edgeViol++;
    prevOe = sdaOe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q); sdaM = 1'b0; tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(Q); sclM = 1'b1; tick(Q); sdaM = 1'b1; tick(Q);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; tick(Q); sclM = 1'b1; tick(Q); tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic recvBit(output logic b);
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q); b = sdaLine; tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(x);
    ack = ~x;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] d);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      recvBit(x);
      d[i] = x;
    end
    sendBit(~ackIt);
  endtask

  task automatic usrRead(input int a, output logic [7:0] d);
    usrAddr = 5'(a); tick(1); d = usrRdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int hitIdx, reg0, k;

    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    tick(5);
    rstN = 1'b1;
    tick(5);

    // R1 reset state
    chk("R1 sdaOe", sdaOe, 0);
    for (int i = 0; i < 32; i++) begin
      usrRead(i, d);
      chk("R1 reg", d, 0);
    end

    // R2 R3 R4: every strap code against every candidate address
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      hitIdx = (s == 1) ? 1 : (s == 2) ? 2 : 0;
      for (int c = 0; c < 4; c++) begin
        reg0 = 16 + s * 4 + c;
        busStart();
        sendByte(8'(8'h50 + 2 * c), ack);
        chk("R2 R3 address ack", ack, (c == hitIdx) ? 1 : 0);
        sendByte(8'(reg0), ack);
        chk("R3 R4 register byte ack", ack, (c == hitIdx) ? 1 : 0);
        sendByte(8'(8'h80 + reg0), ack);
        busStop();
        if (c == hitIdx) model[reg0] = 8'(8'h80 + reg0);
        usrRead(reg0, d);
        chk("R4 R6 register after strap write", d, model[reg0]);
      end
    end
    strap = 2'b00;

    // R5 upper bits of register number ignored
    busStart();
    sendByte(8'h50, ack);
    sendByte(8'h25, ack);
    sendByte(8'h3C, ack);
    chk("R3 data ack", ack, 1);
    busStop();
    model[5] = 8'h3C;
    usrRead(5, d);
    chk("R5 R6 aliased register", d, 8'h3C);

    // R7 burst write wrapping from 0x1E, 36 bytes
    busStart();
    sendByte(8'h50, ack);
    sendByte(8'h1E, ack);
    for (int j = 0; j < 36; j++) begin
      sendByte(8'((j * 37 + 11) & 8'hFF), ack);
      model[(30 + j) % 32] = 8'((j * 37 + 11) & 8'hFF);
    end
    busStop();
    for (int i = 0; i < 32; i++) begin
      usrRead(i, d);
      chk("R7 burst write wrap", d, model[i]);
    end

    // R8 single read with repeated START
    busStart();
    sendByte(8'h50, ack);
    sendByte(8'h03, ack);
    busStart();
    sendByte(8'h51, ack);
    chk("R8 read address ack", ack, 1);
    recvByte(1'b0, d);
    chk("R8 single read", d, model[3]);
    chk("R9 released after nack", sdaOe, 0);
    busStop();

    // R9 burst read wrapping from 0x1C, 40 bytes
    busStart();
    sendByte(8'h50, ack);
    sendByte(8'h1C, ack);
    busStart();
    sendByte(8'h51, ack);
    for (int j = 0; j < 40; j++) begin
      recvByte((j != 39), d);
      k = (28 + j) % 32;
      chk("R9 burst read wrap", d, model[k]);
    end
    chk("R9 silent after nack", sdaOe, 0);
    busStop();

    // R11 STOP in the middle of a data byte
    busStart();
    sendByte(8'h50, ack);
    sendByte(8'h07, ack);
    for (int j = 0; j < 4; j++) sendBit(1'b1);
    busStop();
    usrRead(7, d);
    chk("R11 partial byte not written", d, model[7]);

    // R11 START in the middle of a byte, then a normal write
    busStart();
    sendByte(8'h50, ack);
    sendByte(8'h09, ack);
    for (int j = 0; j < 3; j++) sendBit(1'b0);
    busStart();
    sendByte(8'h50, ack);
    chk("R11 ack after restart", ack, 1);
    sendByte(8'h09, ack);
    sendByte(8'h77, ack);
    busStop();
    model[9] = 8'h77;
    usrRead(9, d);
    chk("R11 write after restart", d, 8'h77);

    // R12 user write visible on the bus
    usrAddr = 5'h1F; usrWdata = 8'h5A; usrWe = 1'b1; tick(1); usrWe = 1'b0;
    model[31] = 8'h5A;
    usrRead(31, d);
    chk("R12 user port readback", d, 8'h5A);
    busStart();
    sendByte(8'h50, ack);
    sendByte(8'h1F, ack);
    busStart();
    sendByte(8'h51, ack);
    recvByte(1'b1, d);
    chk("R12 bus read of user value", d, 8'h5A);
    recvByte(1'b0, d);
    chk("R9 wrap to first register", d, model[0]);
    busStop();

    tick(4);
    chk("R10 sda moves only with scl low", edgeViol, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule